// File: doc/BRIEF.md
# Program Counter and Call-Stack Unit

This block owns the program counter and the stack pointer of a small 8-bit controller core and works out where execution goes next. The decoder hands it one control-flow instruction at a time: the opcode, up to two operand bytes, the instruction length, the accumulator, the 16-bit data pointer and a taken flag from the condition logic elsewhere. From these the unit selects one of several next-address sources. These are the following address, a 2 KB in-page absolute target, a full 16-bit target, a signed 8-bit relative displacement or the data pointer plus accumulator. It then loads its program counter.

Subroutine calls, returns, and single-byte push and pop drive a byte-wide port to an external stack memory. That memory returns read data one cycle after the read strobe. A call spends two cycles writing the return address. A return spends three cycles, reading two bytes and then loading the program counter. While such a sequence runs, `ready` is low and new issues are ignored. For the code-table read form, the unit also produces the table address. The arithmetic instructions and the memory arrays sit outside it.

Top module: `pc_stack_unit`

## Requirements
- R1: After reset `pc` is 0000h, `sp` is 07h, `ready` is 1 and neither `stk_we` nor `stk_re` is asserted.
- R2: An accepted opcode that is not a control-flow code loads `pc` with `pc + ilen` modulo 65536, with `ilen` read as 1, 2 or 3.
- R3: An opcode whose low five bits are 00001b (an in-page jump) loads `pc` with bits 15..11 of `pc + ilen`, then opcode bits 7..5, then `op1` as bits 7..0.
- R4: An opcode whose low five bits are 10001b (an in-page call) writes the low byte of `pc + ilen` at `sp+1`, then the high byte at `sp+2` in the next cycle. It leaves `sp` two higher and loads `pc` as in R3. `ready` is low in the second cycle.
- R5: Opcode 02h loads `pc` with `{op1, op2}`. Opcode 12h pushes `pc + ilen` with the same two-cycle order as R4 and then loads `{op1, op2}`.
- R6: Opcodes 22h and 32h read at `sp` (high byte) and then at `sp-1` (low byte). They leave `sp` two lower and in the third cycle load `pc` with the two bytes. Read data is taken the cycle after its strobe.
- R7: Opcode 80h always, and the conditional opcodes 10h, 20h, 30h, 40h, 50h, 60h, 70h, B4h..BFh, D5h and D8h..DFh when `taken` is 1, load `pc + ilen` plus the sign-extended last operand byte (`op2` when `ilen` is 3, else `op1`). A conditional opcode with `taken` 0 loads `pc + ilen`.
- R8: Opcode 73h loads `pc` with `dptr + acc` modulo 65536.
- R9: Opcodes 93h and 83h assert `code_rd` in the issue cycle, with `code_addr` equal to `dptr + acc` (93h) or `pc + 1 + acc` (83h) modulo 65536. `pc` advances by `ilen`.
- R10: Opcode C0h writes `push_byte` at `sp+1`, leaves `sp` one higher and advances `pc` by `ilen`, all in one cycle.
- R11: Opcode D0h reads at `sp` and leaves `sp` one lower. In the next cycle it asserts `pop_valid` with the returned byte on `pop_data`, with `ready` low.
- R12: An `issue` presented while `ready` is low has no effect on `pc`, `sp` or the stack port.
- R13: `sp` arithmetic wraps modulo 256: a pop at 00h leaves FFh, and a push at FFh writes address 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue | input | 1 | Instruction presented; taken only when `ready` is 1 |
| opcode | input | 8 | First instruction byte |
| op1 | input | 8 | Second instruction byte |
| op2 | input | 8 | Third instruction byte |
| ilen | input | 2 | Instruction length in bytes (1 to 3) |
| acc | input | 8 | Accumulator value |
| dptr | input | 16 | Data pointer value |
| taken | input | 1 | Condition result for conditional branches |
| push_byte | input | 8 | Byte to store for a single push |
| stk_rdata | input | 8 | Stack memory read data, valid one cycle after `stk_re` |
| ready | output | 1 | Unit idle and able to accept an issue |
| pc | output | 16 | Program counter |
| sp | output | 8 | Stack pointer |
| stk_we | output | 1 | Stack memory write strobe |
| stk_re | output | 1 | Stack memory read strobe |
| stk_addr | output | 8 | Stack memory address |
| stk_wdata | output | 8 | Stack memory write data |
| code_rd | output | 1 | Code-table read request |
| code_addr | output | 16 | Code-table read address |
| pop_valid | output | 1 | Popped byte present on `pop_data` |
| pop_data | output | 8 | Popped byte |

## Verification
The bench aims at the in-page jump issued from FFFEh, where the page bits must come from the wrapped following address (0000h) and not from the instruction's own address. A design that used the wrong base would land in page 1Fh. It also checks that calls and returns use opposite byte orders. It checks the -128 displacement, which a zero-extending adder would turn into +128, and a stack pointer that passes from 00h to FFh and back. An overlapping long jump is held on `issue` throughout a call's second cycle; a unit that sampled it would leave the call target behind.

// File: rtl/psu_pkg.sv
package psu_pkg;

  // Control-flow class of the presented opcode
  typedef enum logic [3:0] {
    K_SEQ,
    K_AJMP,
    K_ACALL,
    K_LJMP,
    K_LCALL,
    K_RET,
    K_REL,
    K_COND,
    K_IJMP,
    K_MOVC_DP,
    K_MOVC_PC,
    K_PUSH,
    K_POP
  } kind_t;

  // Multi-cycle sequencer states
  typedef enum logic [2:0] {
    S_IDLE,
    S_CALL2,
    S_RET2,
    S_RET3,
    S_POPW
  } state_t;

endpackage

// File: rtl/psu_decode.sv
module psu_decode
  import psu_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic [DW-1:0] opcode,
  output kind_t         kind
);

  // Only the control-flow codes are recognised; everything else is sequential.
  always_comb begin
    kind = K_SEQ;
    casez (opcode)
      8'b???0_0001: kind = K_AJMP;
      8'b???1_0001: kind = K_ACALL;
      8'h02:        kind = K_LJMP;
      8'h12:        kind = K_LCALL;
      8'h22, 8'h32: kind = K_RET;
      8'h80:        kind = K_REL;
      8'h10, 8'h20, 8'h30, 8'h40,
      8'h50, 8'h60, 8'h70:  kind = K_COND;
      8'b1011_01??: kind = K_COND;
      8'b1011_1???: kind = K_COND;
      8'hD5:        kind = K_COND;
      8'b1101_1???: kind = K_COND;
      8'h73:        kind = K_IJMP;
      8'h93:        kind = K_MOVC_DP;
      8'h83:        kind = K_MOVC_PC;
      8'hC0:        kind = K_PUSH;
      8'hD0:        kind = K_POP;
      default:      kind = K_SEQ;
    endcase
  end

endmodule

// File: rtl/psu_target.sv
module psu_target
  import psu_pkg::*;
#(
  parameter int AW     = 16,
  parameter int DW     = 8,
  parameter int PAGE_W = 11,
  parameter int LEN_W  = 2
) (
  input  logic [AW-1:0]          pc,
  input  kind_t                  kind,
  input  logic [PAGE_W-DW-1:0]   page_bits,
  input  logic [DW-1:0]          op1,
  input  logic [DW-1:0]          op2,
  input  logic [LEN_W-1:0]       ilen,
  input  logic [DW-1:0]          acc,
  input  logic [AW-1:0]          dptr,
  input  logic                   taken,
  output logic [AW-1:0]          seq_pc,
  output logic [AW-1:0]          jump_pc,
  output logic [AW-1:0]          code_addr
);

  localparam int PG = PAGE_W - DW;

  // Address sum; truncation to AW bits gives the modulo wrap.
  function automatic logic [AW-1:0] add_wrap(input logic [AW-1:0] a,
                                             input logic [AW-1:0] b);
    return a + b;
  endfunction

  function automatic logic [AW-1:0] zext_byte(input logic [DW-1:0] v);
    return {{(AW-DW){1'b0}}, v};
  endfunction

  function automatic logic [AW-1:0] sext_byte(input logic [DW-1:0] v);
    return {{(AW-DW){v[DW-1]}}, v};
  endfunction

  // In-page target: upper bits from the following address, page from opcode.
  function automatic logic [AW-1:0] page_target(input logic [AW-1:0] nxt,
                                                input logic [PG-1:0] pg,
                                                input logic [DW-1:0] lo);
    return {nxt[AW-1:PAGE_W], pg, lo};
  endfunction

  logic [AW-1:0] rel_pc;
  logic [DW-1:0] disp;

  assign seq_pc = add_wrap(pc, {{(AW-LEN_W){1'b0}}, ilen});
  // The displacement is always the last byte of the instruction.
  assign disp   = (ilen == LEN_W'(3)) ? op2 : op1;
  assign rel_pc = add_wrap(seq_pc, sext_byte(disp));

  always_comb begin
    unique case (kind)
      K_MOVC_PC: code_addr = add_wrap(add_wrap(pc, {{(AW-1){1'b0}}, 1'b1}),
                                      zext_byte(acc));
      default:   code_addr = add_wrap(dptr, zext_byte(acc));
    endcase
  end

  always_comb begin
    jump_pc = seq_pc;
    case (kind)
      K_AJMP, K_ACALL: jump_pc = page_target(seq_pc, page_bits, op1);
      K_LJMP, K_LCALL: jump_pc = {op1, op2};
      K_REL:           jump_pc = rel_pc;
      K_COND:          jump_pc = taken ? rel_pc : seq_pc;
      K_IJMP:          jump_pc = add_wrap(dptr, zext_byte(acc));
      default:         jump_pc = seq_pc;
    endcase
  end

endmodule

// File: rtl/psu_seq.sv
module psu_seq
  import psu_pkg::*;
#(
  parameter int          AW       = 16,
  parameter int          DW       = 8,
  parameter logic [DW-1:0] SP_RESET = 8'h07
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          issue,
  input  kind_t         kind,
  input  logic [AW-1:0] seq_pc,
  input  logic [AW-1:0] jump_pc,
  input  logic [DW-1:0] push_byte,
  input  logic [DW-1:0] stk_rdata,
  output logic          ready,
  output logic          accept,
  output logic [DW-1:0] sp,
  output logic          stk_we,
  output logic          stk_re,
  output logic [DW-1:0] stk_addr,
  output logic [DW-1:0] stk_wdata,
  output logic          pop_valid,
  output logic [DW-1:0] pop_data,
  output logic          pc_ld,
  output logic [AW-1:0] pc_val,
  output logic          call_start,
  output logic          ret_done
);

  state_t        state_q, state_d;
  logic [DW-1:0] sp_q, sp_d;
  logic [AW-1:0] tgt_q;
  logic [DW-1:0] byte_q;
  logic [DW-1:0] sp_up, sp_dn;

  assign sp_up      = sp_q + 1'b1;
  assign sp_dn      = sp_q - 1'b1;
  assign ready      = (state_q == S_IDLE);
  assign accept     = ready && issue;
  assign call_start = accept && (kind == K_ACALL || kind == K_LCALL);
  assign ret_done   = (state_q == S_RET3);
  assign sp         = sp_q;
  assign pop_data   = stk_rdata;

  always_comb begin
    state_d   = state_q;
    sp_d      = sp_q;
    stk_we    = 1'b0;
    stk_re    = 1'b0;
    stk_addr  = sp_up;
    stk_wdata = '0;
    pop_valid = 1'b0;
    pc_ld     = 1'b0;
    pc_val    = jump_pc;
    case (state_q)
      S_IDLE: begin
        if (issue) begin
          case (kind)
            K_ACALL, K_LCALL: begin
              // Return address low byte goes first
              stk_we    = 1'b1;
              stk_wdata = seq_pc[DW-1:0];
              sp_d      = sp_up;
              state_d   = S_CALL2;
            end
            K_RET: begin
              // High byte sits on top of the stack
              stk_re   = 1'b1;
              stk_addr = sp_q;
              sp_d     = sp_dn;
              state_d  = S_RET2;
            end
            K_PUSH: begin
              stk_we    = 1'b1;
              stk_wdata = push_byte;
              sp_d      = sp_up;
              pc_ld     = 1'b1;
            end
            K_POP: begin
              stk_re   = 1'b1;
              stk_addr = sp_q;
              sp_d     = sp_dn;
              pc_ld    = 1'b1;
              state_d  = S_POPW;
            end
            default: pc_ld = 1'b1;
          endcase
        end
      end
      S_CALL2: begin
        stk_we    = 1'b1;
        stk_wdata = byte_q;
        sp_d      = sp_up;
        pc_ld     = 1'b1;
        pc_val    = tgt_q;
        state_d   = S_IDLE;
      end
      S_RET2: begin
        stk_re   = 1'b1;
        stk_addr = sp_q;
        sp_d     = sp_dn;
        state_d  = S_RET3;
      end
      S_RET3: begin
        pc_ld   = 1'b1;
        pc_val  = {byte_q, stk_rdata};
        state_d = S_IDLE;
      end
      S_POPW: begin
        pop_valid = 1'b1;
        state_d   = S_IDLE;
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      sp_q    <= SP_RESET;
      tgt_q   <= '0;
      byte_q  <= '0;
    end else begin
      state_q <= state_d;
      sp_q    <= sp_d;
      if (call_start) begin
        tgt_q  <= jump_pc;
        byte_q <= seq_pc[AW-1:DW];
      end else if (state_q == S_RET2) begin
        byte_q <= stk_rdata;
      end
    end
  end

endmodule

// File: rtl/pc_stack_unit.sv
module pc_stack_unit
  import psu_pkg::*;
#(
  parameter int            AW       = 16,
  parameter int            DW       = 8,
  parameter int            PAGE_W   = 11,
  parameter int            LEN_W    = 2,
  parameter logic [DW-1:0] SP_RESET = 8'h07
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             issue,
  input  logic [DW-1:0]    opcode,
  input  logic [DW-1:0]    op1,
  input  logic [DW-1:0]    op2,
  input  logic [LEN_W-1:0] ilen,
  input  logic [DW-1:0]    acc,
  input  logic [AW-1:0]    dptr,
  input  logic             taken,
  input  logic [DW-1:0]    push_byte,
  input  logic [DW-1:0]    stk_rdata,
  output logic             ready,
  output logic [AW-1:0]    pc,
  output logic [DW-1:0]    sp,
  output logic             stk_we,
  output logic             stk_re,
  output logic [DW-1:0]    stk_addr,
  output logic [DW-1:0]    stk_wdata,
  output logic             code_rd,
  output logic [AW-1:0]    code_addr,
  output logic             pop_valid,
  output logic [DW-1:0]    pop_data
);

  localparam int PG = PAGE_W - DW;

  kind_t         kind;
  logic [AW-1:0] pc_q;
  logic [AW-1:0] seq_pc;
  logic [AW-1:0] jump_pc;
  logic [AW-1:0] pc_val;
  logic          pc_ld;
  logic          accept;
  logic          call_start;
  logic          ret_done;

  psu_decode #(.DW(DW)) u_dec (
    .opcode (opcode),
    .kind   (kind)
  );

  psu_target #(.AW(AW), .DW(DW), .PAGE_W(PAGE_W), .LEN_W(LEN_W)) u_tgt (
    .pc        (pc_q),
    .kind      (kind),
    .page_bits (opcode[DW-1 -: PG]),
    .op1       (op1),
    .op2       (op2),
    .ilen      (ilen),
    .acc       (acc),
    .dptr      (dptr),
    .taken     (taken),
    .seq_pc    (seq_pc),
    .jump_pc   (jump_pc),
    .code_addr (code_addr)
  );

  psu_seq #(.AW(AW), .DW(DW), .SP_RESET(SP_RESET)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .issue      (issue),
    .kind       (kind),
    .seq_pc     (seq_pc),
    .jump_pc    (jump_pc),
    .push_byte  (push_byte),
    .stk_rdata  (stk_rdata),
    .ready      (ready),
    .accept     (accept),
    .sp         (sp),
    .stk_we     (stk_we),
    .stk_re     (stk_re),
    .stk_addr   (stk_addr),
    .stk_wdata  (stk_wdata),
    .pop_valid  (pop_valid),
    .pop_data   (pop_data),
    .pc_ld      (pc_ld),
    .pc_val     (pc_val),
    .call_start (call_start),
    .ret_done   (ret_done)
  );

  assign code_rd = accept && (kind == K_MOVC_DP || kind == K_MOVC_PC);
  assign pc      = pc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pc_q <= '0;
    else if (pc_ld) pc_q <= pc_val;
  end

endmodule

// File: rtl/psu_checker.sv
module psu_checker
  import psu_pkg::*;
#(
  parameter int AW     = 16,
  parameter int DW     = 8,
  parameter int PAGE_W = 11
) (
  input logic          clk,
  input logic          rst_n,
  input logic          accept,
  input kind_t         kind,
  input logic          ready,
  input logic          stk_we,
  input logic          stk_re,
  input logic [DW-1:0] stk_addr,
  input logic [DW-1:0] stk_rdata,
  input logic [DW-1:0] sp,
  input logic [AW-1:0] pc,
  input logic [AW-1:0] seq_pc,
  input logic          pop_valid,
  input logic          call_start,
  input logic          ret_done
);

  // R2
  seq_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && kind == K_SEQ) |=> (pc == $past(seq_pc)));

  // R3
  page_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && kind == K_AJMP) |=> (pc[AW-1:PAGE_W] == $past(seq_pc[AW-1:PAGE_W])));

  // R4
  call_second_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    call_start |=> (stk_we && !ready && stk_addr == $past(stk_addr) + 8'd1));

  // R10
  write_at_new_sp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stk_we |=> (sp == $past(stk_addr)));

  // R11
  read_then_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stk_re |=> (sp == $past(stk_addr) - 8'd1));

  // R11
  pop_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop_valid |-> $past(stk_re));

  // R6
  ret_low_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ret_done |=> (pc[DW-1:0] == $past(stk_rdata)));

endmodule

bind pc_stack_unit psu_checker #(.AW(AW), .DW(DW), .PAGE_W(PAGE_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .accept     (accept),
  .kind       (kind),
  .ready      (ready),
  .stk_we     (stk_we),
  .stk_re     (stk_re),
  .stk_addr   (stk_addr),
  .stk_rdata  (stk_rdata),
  .sp         (sp),
  .pc         (pc),
  .seq_pc     (seq_pc),
  .pop_valid  (pop_valid),
  .call_start (call_start),
  .ret_done   (ret_done)
);

// File: tb/sim_pc_stack_unit.sv
`timescale 1ns/100ps
module sim_pc_stack_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        issue = 1'b0;
  logic [7:0]  opcode = 8'h00, op1 = 8'h00, op2 = 8'h00;
  logic [1:0]  ilen = 2'd1;
  logic [7:0]  acc = 8'h00;
  logic [15:0] dptr = 16'h0000;
  logic        taken = 1'b0;
  logic [7:0]  push_byte = 8'h00;
  logic [7:0]  stk_rdata;
  logic        ready, stk_we, stk_re, code_rd, pop_valid;
  logic [15:0] pc, code_addr;
  logic [7:0]  sp, stk_addr, stk_wdata, pop_data;

  always #2.5 clk = ~clk;

  pc_stack_unit u0 (
    .clk(clk), .rst_n(rst_n), .issue(issue), .opcode(opcode), .op1(op1),
    .op2(op2), .ilen(ilen), .acc(acc), .dptr(dptr), .taken(taken),
    .push_byte(push_byte), .stk_rdata(stk_rdata), .ready(ready), .pc(pc),
    .sp(sp), .stk_we(stk_we), .stk_re(stk_re), .stk_addr(stk_addr),
    .stk_wdata(stk_wdata), .code_rd(code_rd), .code_addr(code_addr),
    .pop_valid(pop_valid), .pop_data(pop_data)
  );

  // Stack memory seen by the design: one-cycle read latency
  logic [7:0] mem [256];
  logic [7:0] rd_q = 8'h00;
  assign stk_rdata = rd_q;
  always @(posedge clk) begin
    if (stk_we) mem[stk_addr] <= stk_wdata;
    if (stk_re) rd_q <= mem[stk_addr];
  end

  // Reference model state
  int ref_pc, ref_sp;
  int ref_stk [256];
  int n_tests = 0, n_fail = 0;
  bit noise = 0;
  bit done = 0;

  typedef struct { bit we; bit re; int addr; int wd; bit pv; int pd; } ev_t;

  task automatic chk(input string tag, input int act, input int exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit is_cond(input int op);
    if (op == 'h10 || op == 'h20 || op == 'h30 || op == 'h40) return 1;
    if (op == 'h50 || op == 'h60 || op == 'h70 || op == 'hD5) return 1;
    if (op >= 'hB4 && op <= 'hBF) return 1;
    if (op >= 'hD8 && op <= 'hDF) return 1;
    return 0;
  endfunction

  task automatic exec(input string tag, input int op, input int o1, input int o2,
                      input int len, input int a, input int dp, input bit tk,
                      input int pb);
    ev_t q[$];
    ev_t e;
    int nxt, npc, off, s1, hi, lo;
    bit ecrd;
    int ecad;
    nxt  = (ref_pc + len) % 65536;
    npc  = nxt;
    ecrd = 0;
    ecad = 0;
    e = '{0, 0, 0, 0, 0, 0};
    off = (len == 3) ? o2 : o1;
    if (off >= 128) off = off - 256;
    if ((op % 32) == 1 || (op % 32) == 17) begin
      npc = (nxt / 2048) * 2048 + (op / 32) * 256 + o1;
    end
    if (op == 'h02 || op == 'h12) npc = o1 * 256 + o2;
    if ((op % 32) == 17 || op == 'h12) begin
      s1 = (ref_sp + 1) % 256;
      ref_stk[s1] = nxt % 256;
      q.push_back('{1, 0, s1, nxt % 256, 0, 0});
      s1 = (ref_sp + 2) % 256;
      ref_stk[s1] = nxt / 256;
      q.push_back('{1, 0, s1, nxt / 256, 0, 0});
      ref_sp = s1;
    end else if (op == 'h22 || op == 'h32) begin
      hi = ref_stk[ref_sp];
      s1 = (ref_sp + 255) % 256;
      lo = ref_stk[s1];
      q.push_back('{0, 1, ref_sp, 0, 0, 0});
      q.push_back('{0, 1, s1, 0, 0, 0});
      q.push_back(e);
      ref_sp = (ref_sp + 254) % 256;
      npc = hi * 256 + lo;
    end else if (op == 'hC0) begin
      s1 = (ref_sp + 1) % 256;
      ref_stk[s1] = pb;
      q.push_back('{1, 0, s1, pb, 0, 0});
      ref_sp = s1;
    end else if (op == 'hD0) begin
      q.push_back('{0, 1, ref_sp, 0, 0, 0});
      q.push_back('{0, 0, 0, 0, 1, ref_stk[ref_sp]});
      ref_sp = (ref_sp + 255) % 256;
    end else begin
      q.push_back(e);
    end
    if (op == 'h80 || (is_cond(op) && tk)) npc = (nxt + off + 65536) % 65536;
    if (op == 'h73) npc = (dp + a) % 65536;
    if (op == 'h93) begin ecrd = 1; ecad = (dp + a) % 65536; end
    if (op == 'h83) begin ecrd = 1; ecad = (ref_pc + 1 + a) % 65536; end
    ref_pc = npc;

    @(negedge clk);
    issue = 1; opcode = op[7:0]; op1 = o1[7:0]; op2 = o2[7:0]; ilen = len[1:0];
    acc = a[7:0]; dptr = dp[15:0]; taken = tk; push_byte = pb[7:0];
    for (int i = 0; i < q.size(); i++) begin
      if (i > 0) begin
        @(negedge clk);
        if (noise) begin
          issue = 1; opcode = 8'h02; op1 = 8'hAA; op2 = 8'h55; ilen = 2'd3;
        end else issue = 0;
      end
      #1;
      chk({tag, " ready"}, ready, (i == 0) ? 1 : 0);
      chk({tag, " strobes"}, {stk_we, stk_re}, {q[i].we, q[i].re});
      if (q[i].we) chk({tag, " wdata"}, stk_wdata, q[i].wd);
      if (q[i].we || q[i].re) chk({tag, " stk_addr"}, stk_addr, q[i].addr);
      chk({tag, " pop_valid"}, pop_valid, q[i].pv);
      if (q[i].pv) chk({tag, " pop_data"}, pop_data, q[i].pd);
      chk({tag, " code_rd"}, code_rd, (i == 0) ? ecrd : 0);
      if (i == 0 && ecrd) chk({tag, " code_addr"}, code_addr, ecad);
    end
    @(negedge clk);
    issue = 0;
    #1;
    chk({tag, " ready after"}, ready, 1);
    chk({tag, " pc"}, pc, ref_pc);
    chk({tag, " sp"}, sp, ref_sp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired (all requirements) actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) begin mem[i] = 8'h00; ref_stk[i] = 0; end
    ref_pc = 0;
    ref_sp = 'h07;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    // R1: reset state
    chk("R1 pc", pc, 0);
    chk("R1 sp", sp, 'h07);
    chk("R1 ready", ready, 1);
    chk("R1 strobes", {stk_we, stk_re}, 0);

    exec("R2 one-byte", 'h00, 0, 0, 1, 0, 0, 0, 0);
    exec("R2 three-byte", 'h75, 'h11, 'h22, 3, 0, 0, 0, 0);
    exec("R5 long jump", 'h02, 'h12, 'h34, 3, 0, 0, 0, 0);
    exec("R3 page7 jump", 'hE1, 'h5A, 0, 2, 0, 0, 0, 0);
    noise = 1;
    exec("R4 call R12 busy", 'h31, 'h20, 0, 2, 0, 0, 0, 0);
    noise = 0;
    exec("R5 long call", 'h12, 'h40, 'h00, 3, 0, 0, 0, 0);
    exec("R6 return", 'h22, 0, 0, 1, 0, 0, 0, 0);
    noise = 1;
    exec("R6 return-irq R12", 'h32, 0, 0, 1, 0, 0, 0, 0);
    noise = 0;
    exec("R7 short back", 'h80, 'hFE, 0, 2, 0, 0, 0, 0);
    exec("R7 cond taken fwd", 'h70, 'h7F, 0, 2, 0, 0, 1, 0);
    exec("R7 three-byte -128", 'hB5, 'h33, 'h80, 3, 0, 0, 1, 0);
    exec("R7 not taken", 'h40, 'h10, 0, 2, 0, 0, 0, 0);
    exec("R7 not taken 3b", 'hD5, 'h30, 'h10, 3, 0, 0, 0, 0);
    exec("R8 indexed wrap", 'h73, 0, 0, 1, 'hF0, 'hFFF0, 0, 0);
    exec("R9 table dptr", 'h93, 0, 0, 1, 'h10, 'h2000, 0, 0);
    exec("R9 table pc", 'h83, 0, 0, 1, 'hFF, 'h2000, 0, 0);
    exec("R10 push", 'hC0, 'h44, 0, 2, 0, 0, 0, 'hA5);
    exec("R11 pop", 'hD0, 'h44, 0, 2, 0, 0, 0, 0);
    for (int k = 0; k < 8; k++) exec("R13 pop down", 'hD0, 'h50, 0, 2, 0, 0, 0, 0);
    exec("R13 push wrap", 'hC0, 'h60, 0, 2, 0, 0, 0, 'h3C);
    exec("R13 pop wrap", 'hD0, 'h60, 0, 2, 0, 0, 0, 0);
    exec("R5 jump top", 'h02, 'hFF, 'hFE, 3, 0, 0, 0, 0);
    exec("R3 page from wrapped", 'h21, 'h34, 0, 2, 0, 0, 0, 0);
    exec("R5 jump end", 'h02, 'hFF, 'hFF, 3, 0, 0, 0, 0);
    exec("R2 wrap to zero", 'h00, 0, 0, 1, 0, 0, 0, 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule